// File: doc/BRIEF.md
# PLL Reconfiguration Sequencer

This block owns the control, divider, numerator and denominator words that drive a fractional-N PLL. It changes them in a fixed order when it receives one of three commands. A set-rate command powers the loop down and loads new divider values. It then lets them settle, powers the loop up, waits for lock, enables the output and checks the fractional value the PLL reports back. A prepare command brings a powered-down PLL up through its bypass path. An unprepare command powers it down.

Waits are counted in microseconds. A tick generator derives each microsecond from a clock-frequency parameter. The lock wait ends with an error once a fixed limit is reached. The analog loop itself is outside the block. Its lock indication and its echoed fractional numerator arrive on input pins.

Top module: `pll_reseq`

## Requirements
- R1: After reset, the control word is 0x0001_0000: hardware-select bit 16 is set and bits 2 (bypass), 1 (output enable) and 0 (power-up) are clear. The divider, numerator and denominator words are 0, and `busy`, `done`, `numLoad`, `seqError` and `mfnMismatch` are low.
- R2: `cmdOp` encodes 01 = set-rate, 10 = prepare, 11 = unprepare and 00 = nothing. A command is taken only when `cmdValid` is high and `busy` is low; a command presented while busy is dropped. `busy` stays high until the sequence ends. `done` is high for exactly one cycle at the end of each sequence, and `busy` is low the cycle after.
- R3: Set-rate changes at most one control bit per cycle. It clears bit 16, then bit 1, then bit 0, then bit 2. It then loads the divider word with MFI in bits 24:16, RDIV in bits 15:13 and ODIV in bits 7:0. The divider is written only while bits 2:0 are all clear.
- R4: With `fracMode` high, set-rate loads the denominator word (MFD in bits 29:0) and then the numerator word (MFN in bits 31:2). Each numerator write pulses `numLoad` for one cycle. With `fracMode` low, neither word changes and `numLoad` stays low.
- R5: In set-rate, power-up (bit 0) is set no earlier than 5 µs after the last divider or fraction write, and within 15 clock cycles after that.
- R6: If lock is not seen within 200 µs of power-up during set-rate, the sequence ends with `seqError` high and output enable (bit 1) clear.
- R7: Once lock is seen during set-rate, bit 1 is set and `pllMfnEcho` is compared with the requested MFN. `mfnMismatch` goes high if they differ. Both `seqError` and `mfnMismatch` are cleared when any command is accepted.
- R8: Prepare with bit 0 already set leaves the control word unchanged, writes nothing and signals `done` within 3 cycles of acceptance.
- R9: Prepare with bit 0 clear pulses `numLoad` once if `fracMode` is high, without changing the numerator. It then sets bit 2, then bit 0, then bit 1, waits for lock and clears bit 2. On a 200 µs lock timeout it ends with `seqError` high and bits 2:0 left set.
- R10: Unprepare clears bit 0 only; all other control bits keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command request |
| cmdOp | input | 2 | Command code (R2) |
| fracMode | input | 1 | Fractional mode for this command |
| reqMfi | input | 9 | Requested integer multiplier |
| reqRdiv | input | 3 | Requested reference divider |
| reqOdiv | input | 8 | Requested output divider |
| reqMfn | input | 30 | Requested fractional numerator |
| reqMfd | input | 30 | Requested fractional denominator |
| pllLock | input | 1 | Lock indication from the PLL |
| pllMfnEcho | input | 30 | Numerator value reported back by the PLL |
| ctrlWord | output | 32 | Control word driving the PLL |
| divWord | output | 32 | Divider word |
| numWord | output | 32 | Numerator word |
| denWord | output | 32 | Denominator word |
| numLoad | output | 1 | One-cycle pulse on each numerator write |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle end-of-sequence pulse |
| seqError | output | 1 | Last sequence hit the lock timeout |
| mfnMismatch | output | 1 | Echoed numerator differed from the request |

## Verification
The bench records every change of the control word during each command and compares it with the expected ordered list. A design that merged two steps, or cleared power before output enable, would produce a different list.

Both timeout paths run with lock held off. A design that forgot the bypass bit, or left output enable set after a set-rate timeout, would end in the wrong control value. The interval from the last write to power-up, and from power-up to the timeout `done`, is measured in cycles. This catches a timer that is not cleared between waits or a tick divider that is off by a factor.

A command issued mid-sequence must leave no trace. A forced wrong echo must raise the mismatch flag, and the next command must clear both flags.

// File: rtl/pll_reseq_pkg.sv
package pll_reseq_pkg;

  localparam int MFI_W  = 9;
  localparam int RDIV_W = 3;
  localparam int ODIV_W = 8;
  localparam int FRAC_W = 30;

  // bit positions the PLL decodes
  localparam int CTRL_HWSEL   = 16;
  localparam int CTRL_BYP     = 2;
  localparam int CTRL_OE      = 1;
  localparam int CTRL_PWR     = 0;
  localparam int DIV_MFI_LSB  = 16;
  localparam int DIV_RDIV_LSB = 13;
  localparam int DIV_ODIV_LSB = 0;
  localparam int NUM_LSB      = 2;
  localparam int DEN_LSB      = 0;

  typedef enum logic [1:0] {
    OP_NONE    = 2'b00,
    OP_SETRATE = 2'b01,
    OP_PREPARE = 2'b10,
    OP_UNPREP  = 2'b11
  } seqOp_t;

  typedef enum logic [4:0] {
    ST_IDLE, ST_HWSEL, ST_OEOFF, ST_PDOWN, ST_BYPOFF, ST_DIV, ST_DEN, ST_NUM,
    ST_SETTLE, ST_PUP, ST_LOCK, ST_OEON, ST_CHK,
    ST_P_NUM, ST_P_BYP, ST_P_PUP, ST_P_OE, ST_P_LOCK, ST_P_UNBYP,
    ST_U_PD, ST_FIN
  } seqState_t;

  typedef struct packed {
    logic latchReq;
    logic clrFlags;
    logic clrHwSel;
    logic clrOutEn;
    logic setOutEn;
    logic clrPwr;
    logic setPwr;
    logic clrByp;
    logic setByp;
    logic wrDiv;
    logic wrDen;
    logic wrNum;
    logic rwNum;
    logic timerClr;
    logic chkMfn;
    logic setErr;
  } seqStrobe_t;

endpackage

// File: rtl/pll_reseq_tick.sv
module pll_reseq_tick #(
  parameter int TICK_DIV = 125
) (
  input  logic clk,
  input  logic rstN,
  input  logic clr,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pll_reseq_ctrl.sv
module pll_reseq_ctrl
  import pll_reseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       fracMode,
  input  logic       pwrOn,
  input  logic       lockSeen,
  input  logic       settleDone,
  input  logic       lockTimeout,
  output seqStrobe_t stb,
  output logic       busy,
  output logic       done
);
  seqState_t state, nextState;
  logic      fracQ;
  seqOp_t    op;

  assign op   = seqOp_t'(cmdOp);
  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);

  always_comb begin
    nextState = state;
    stb       = '0;
    case (state)
      ST_IDLE: if (cmdValid && op != OP_NONE) begin
        stb.latchReq = 1'b1;
        stb.clrFlags = 1'b1;
        case (op)
          OP_SETRATE: nextState = ST_HWSEL;
          OP_PREPARE: nextState = pwrOn ? ST_FIN : (fracMode ? ST_P_NUM : ST_P_BYP);
          default:    nextState = ST_U_PD;
        endcase
      end
      ST_HWSEL:  begin stb.clrHwSel = 1'b1; nextState = ST_OEOFF;  end
      ST_OEOFF:  begin stb.clrOutEn = 1'b1; nextState = ST_PDOWN;  end
      ST_PDOWN:  begin stb.clrPwr   = 1'b1; nextState = ST_BYPOFF; end
      ST_BYPOFF: begin stb.clrByp   = 1'b1; nextState = ST_DIV;    end
      ST_DIV: begin
        stb.wrDiv = 1'b1; stb.timerClr = 1'b1;
        nextState = fracQ ? ST_DEN : ST_SETTLE;
      end
      ST_DEN: begin stb.wrDen = 1'b1; stb.timerClr = 1'b1; nextState = ST_NUM;    end
      ST_NUM: begin stb.wrNum = 1'b1; stb.timerClr = 1'b1; nextState = ST_SETTLE; end
      ST_SETTLE: if (settleDone) nextState = ST_PUP;
      ST_PUP: begin stb.setPwr = 1'b1; stb.timerClr = 1'b1; nextState = ST_LOCK; end
      ST_LOCK: begin
        if (lockSeen)         nextState = ST_OEON;
        else if (lockTimeout) begin stb.setErr = 1'b1; nextState = ST_FIN; end
      end
      ST_OEON:   begin stb.setOutEn = 1'b1; nextState = ST_CHK; end
      ST_CHK:    begin stb.chkMfn   = 1'b1; nextState = ST_FIN; end
      ST_P_NUM:  begin stb.rwNum    = 1'b1; nextState = ST_P_BYP; end
      ST_P_BYP:  begin stb.setByp   = 1'b1; nextState = ST_P_PUP; end
      ST_P_PUP:  begin stb.setPwr   = 1'b1; nextState = ST_P_OE;  end
      ST_P_OE:   begin stb.setOutEn = 1'b1; stb.timerClr = 1'b1; nextState = ST_P_LOCK; end
      ST_P_LOCK: begin
        if (lockSeen)         nextState = ST_P_UNBYP;
        else if (lockTimeout) begin stb.setErr = 1'b1; nextState = ST_FIN; end
      end
      ST_P_UNBYP: begin stb.clrByp = 1'b1; nextState = ST_FIN; end
      ST_U_PD:    begin stb.clrPwr = 1'b1; nextState = ST_FIN; end
      ST_FIN:     nextState = ST_IDLE;
      default:    nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      fracQ <= 1'b0;
    end else begin
      state <= nextState;
      if (stb.latchReq) fracQ <= fracMode;
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN) done |=> !done); // R2

  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN) done |=> !busy); // R2

endmodule

// File: rtl/pll_reseq_dp.sv
module pll_reseq_dp
  import pll_reseq_pkg::*;
#(
  parameter int TICK_DIV        = 125,
  parameter int SETTLE_US       = 5,
  parameter int LOCK_TIMEOUT_US = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic [MFI_W-1:0]  reqMfi,
  input  logic [RDIV_W-1:0] reqRdiv,
  input  logic [ODIV_W-1:0] reqOdiv,
  input  logic [FRAC_W-1:0] reqMfn,
  input  logic [FRAC_W-1:0] reqMfd,
  input  logic              pllLock,
  input  logic [FRAC_W-1:0] pllMfnEcho,
  output logic [31:0]       ctrlWord,
  output logic [31:0]       divWord,
  output logic [31:0]       numWord,
  output logic [31:0]       denWord,
  output logic              numLoad,
  output logic              seqError,
  output logic              mfnMismatch,
  output logic              pwrOn,
  output logic              lockSeen,
  output logic              settleDone,
  output logic              lockTimeout
);
  localparam int LIMIT = (SETTLE_US > LOCK_TIMEOUT_US) ? SETTLE_US : LOCK_TIMEOUT_US;
  localparam int UW    = $clog2(LIMIT + 1);
  localparam logic [UW-1:0] US_MAX = UW'(LIMIT);

  logic              hwSel, byp, outEn, pwr;
  logic [MFI_W-1:0]  mfiQ;
  logic [RDIV_W-1:0] rdivQ;
  logic [ODIV_W-1:0] odivQ;
  logic [FRAC_W-1:0] mfnQ, mfdQ;
  logic [31:0]       divNext, numNext, denNext;
  logic [UW-1:0]     usCount;
  logic              tick;

  pll_reseq_tick #(.TICK_DIV(TICK_DIV)) i_tick (
    .clk (clk),
    .rstN(rstN),
    .clr (stb.timerClr),
    .tick(tick)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          usCount <= '0;
    else if (stb.timerClr)              usCount <= '0;
    else if (tick && usCount != US_MAX) usCount <= usCount + 1'b1;
  end

  assign settleDone  = (usCount >= UW'(SETTLE_US));
  assign lockTimeout = (usCount >= UW'(LOCK_TIMEOUT_US));
  assign lockSeen    = pllLock;
  assign pwrOn       = pwr;

  always_comb begin
    ctrlWord             = '0;
    ctrlWord[CTRL_HWSEL] = hwSel;
    ctrlWord[CTRL_BYP]   = byp;
    ctrlWord[CTRL_OE]    = outEn;
    ctrlWord[CTRL_PWR]   = pwr;
    divNext                              = '0;
    divNext[DIV_MFI_LSB  +: MFI_W]       = mfiQ;
    divNext[DIV_RDIV_LSB +: RDIV_W]      = rdivQ;
    divNext[DIV_ODIV_LSB +: ODIV_W]      = odivQ;
    numNext                              = '0;
    numNext[NUM_LSB +: FRAC_W]           = mfnQ;
    denNext                              = '0;
    denNext[DEN_LSB +: FRAC_W]           = mfdQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hwSel <= 1'b1; byp <= 1'b0; outEn <= 1'b0; pwr <= 1'b0;
      mfiQ <= '0; rdivQ <= '0; odivQ <= '0; mfnQ <= '0; mfdQ <= '0;
      divWord <= '0; numWord <= '0; denWord <= '0;
      numLoad <= 1'b0; seqError <= 1'b0; mfnMismatch <= 1'b0;
    end else begin
      if (stb.clrHwSel) hwSel <= 1'b0;
      if (stb.clrOutEn) outEn <= 1'b0;
      if (stb.setOutEn) outEn <= 1'b1;
      if (stb.clrPwr)   pwr   <= 1'b0;
      if (stb.setPwr)   pwr   <= 1'b1;
      if (stb.clrByp)   byp   <= 1'b0;
      if (stb.setByp)   byp   <= 1'b1;
      if (stb.latchReq) begin
        mfiQ <= reqMfi; rdivQ <= reqRdiv; odivQ <= reqOdiv;
        mfnQ <= reqMfn; mfdQ <= reqMfd;
      end
      if (stb.wrDiv) divWord <= divNext;
      if (stb.wrDen) denWord <= denNext;
      if (stb.wrNum) numWord <= numNext;
      numLoad <= stb.wrNum | stb.rwNum;
      if (stb.clrFlags) begin
        seqError    <= 1'b0;
        mfnMismatch <= 1'b0;
      end
      if (stb.setErr) seqError    <= 1'b1;
      if (stb.chkMfn) mfnMismatch <= (pllMfnEcho != mfnQ);
    end
  end

  AST_ONE_BIT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    $countones(ctrlWord ^ $past(ctrlWord)) <= 1); // R3

  AST_DIV_WHILE_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrDiv |-> (ctrlWord[2:0] == 3'b000)); // R3

  AST_SETTLE_MET: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ctrlWord[CTRL_PWR]) && !ctrlWord[CTRL_BYP]) |-> $past(settleDone)); // R5

  AST_TIMEOUT_OUT_OFF: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(seqError) && !ctrlWord[CTRL_BYP]) |-> !ctrlWord[CTRL_OE]); // R6

endmodule

// File: rtl/pll_reseq.sv
module pll_reseq
  import pll_reseq_pkg::*;
#(
  parameter int CLK_FREQ_HZ     = 125_000_000,
  parameter int SETTLE_US       = 5,
  parameter int LOCK_TIMEOUT_US = 200
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [1:0]  cmdOp,
  input  logic        fracMode,
  input  logic [8:0]  reqMfi,
  input  logic [2:0]  reqRdiv,
  input  logic [7:0]  reqOdiv,
  input  logic [29:0] reqMfn,
  input  logic [29:0] reqMfd,
  input  logic        pllLock,
  input  logic [29:0] pllMfnEcho,
  output logic [31:0] ctrlWord,
  output logic [31:0] divWord,
  output logic [31:0] numWord,
  output logic [31:0] denWord,
  output logic        numLoad,
  output logic        busy,
  output logic        done,
  output logic        seqError,
  output logic        mfnMismatch
);
  localparam int TICK_DIV = CLK_FREQ_HZ / 1_000_000;

  seqStrobe_t stb;
  logic pwrOn, lockSeen, settleDone, lockTimeout;

  pll_reseq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .fracMode(fracMode),
    .pwrOn(pwrOn), .lockSeen(lockSeen), .settleDone(settleDone), .lockTimeout(lockTimeout),
    .stb(stb), .busy(busy), .done(done)
  );

  pll_reseq_dp #(
    .TICK_DIV(TICK_DIV), .SETTLE_US(SETTLE_US), .LOCK_TIMEOUT_US(LOCK_TIMEOUT_US)
  ) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .reqMfi(reqMfi), .reqRdiv(reqRdiv), .reqOdiv(reqOdiv), .reqMfn(reqMfn), .reqMfd(reqMfd),
    .pllLock(pllLock), .pllMfnEcho(pllMfnEcho),
    .ctrlWord(ctrlWord), .divWord(divWord), .numWord(numWord), .denWord(denWord),
    .numLoad(numLoad), .seqError(seqError), .mfnMismatch(mfnMismatch),
    .pwrOn(pwrOn), .lockSeen(lockSeen), .settleDone(settleDone), .lockTimeout(lockTimeout)
  );
endmodule

// File: tb/test_pll_reseq.sv
`timescale 1ns/1ps
module test_pll_reseq;

  localparam int TICKS     = 125;
  localparam int SETTLE_CY = 5 * TICKS;
  localparam int TOUT_CY   = 200 * TICKS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'b00;
  logic fracMode = 1'b0;
  logic [8:0] reqMfi = '0;
  logic [2:0] reqRdiv = '0;
  logic [7:0] reqOdiv = '0;
  logic [29:0] reqMfn = '0, reqMfd = '0;
  logic pllLock;
  logic [29:0] pllMfnEcho;
  logic [31:0] ctrlWord, divWord, numWord, denWord;
  logic numLoad, busy, done, seqError, mfnMismatch;

  always #4 clk = ~clk;

  pll_reseq i_pll_reseq (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .fracMode(fracMode),
    .reqMfi(reqMfi), .reqRdiv(reqRdiv), .reqOdiv(reqOdiv), .reqMfn(reqMfn), .reqMfd(reqMfd),
    .pllLock(pllLock), .pllMfnEcho(pllMfnEcho),
    .ctrlWord(ctrlWord), .divWord(divWord), .numWord(numWord), .denWord(denWord),
    .numLoad(numLoad), .busy(busy), .done(done), .seqError(seqError), .mfnMismatch(mfnMismatch)
  );

  // PLL model
  logic lockEn = 1'b0, badEcho = 1'b0;
  int lockCnt = 0;
  always @(posedge clk) begin
    if (!ctrlWord[0]) lockCnt <= 0;
    else if (lockCnt < 1000) lockCnt <= lockCnt + 1;
  end
  assign pllLock    = lockEn && ctrlWord[0] && (lockCnt >= 20);
  assign pllMfnEcho = badEcho ? (numWord[31:2] ^ 30'h1) : numWord[31:2];

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", rq, what, act, exp);
    end
  endtask

  task automatic chkRange(string rq, string what, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", rq, what, act, lo, hi);
    end
  endtask

  typedef struct {
    string rq;
    logic [31:0] ctrl, dv, num, den;
    logic err, mism;
    int nLoad;
    int nTrace;
    logic [31:0] trace[8];
    bit chkSettle, chkTout, chkShort;
  } exp_t;

  exp_t q[$];

  function automatic exp_t newExp(string rq);
    exp_t e;
    e.rq = rq; e.ctrl = '0; e.dv = '0; e.num = '0; e.den = '0;
    e.err = 1'b0; e.mism = 1'b0; e.nLoad = 0; e.nTrace = 0;
    for (int i = 0; i < 8; i++) e.trace[i] = '0;
    e.chkSettle = 1'b0; e.chkTout = 1'b0; e.chkShort = 1'b0;
    return e;
  endfunction

  // monitor
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [31:0] lastCtrl = '0;
  logic [31:0] trace[$];
  int nLoadCnt = 0, loadCyc = 0, pwrRiseCyc = 0, acceptCyc = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      lastCtrl = ctrlWord;
    end else begin
      if (cmdValid && !busy) begin
        trace.delete(); nLoadCnt = 0; acceptCyc = cyc;
      end
      if (ctrlWord != lastCtrl) trace.push_back(ctrlWord);
      if (ctrlWord[0] && !lastCtrl[0]) pwrRiseCyc = cyc;
      lastCtrl = ctrlWord;
      if (numLoad) begin nLoadCnt++; loadCyc = cyc; end
      if (done) begin
        if (q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R2 unexpected done: actual 1 expected 0");
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(e.rq, "control word", ctrlWord, e.ctrl);
          chk("R3", "divider word", divWord, e.dv);
          chk("R4", "numerator word", numWord, e.num);
          chk("R4", "denominator word", denWord, e.den);
          chk(e.rq, "error flag", {31'b0, seqError}, {31'b0, e.err});
          chk("R7", "mismatch flag", {31'b0, mfnMismatch}, {31'b0, e.mism});
          chk("R4", "numLoad pulses", nLoadCnt, e.nLoad);
          chk(e.rq, "control change count", trace.size(), e.nTrace);
          for (int i = 0; i < e.nTrace && i < trace.size(); i++)
            chk(e.rq, "control step", trace[i], e.trace[i]);
          if (e.chkSettle) chkRange("R5", "write-to-powerup cycles", pwrRiseCyc - loadCyc, SETTLE_CY, SETTLE_CY + 15);
          if (e.chkTout)   chkRange(e.rq, "powerup-to-timeout cycles", cyc - pwrRiseCyc, TOUT_CY, TOUT_CY + 10);
          if (e.chkShort)  chkRange("R8", "accept-to-done cycles", cyc - acceptCyc, 1, 3);
        end
      end
    end
  end

  // driver
  task automatic sendCmd(logic [1:0] op, logic frac, logic [8:0] mfi, logic [2:0] rdiv,
                         logic [7:0] odiv, logic [29:0] mfn, logic [29:0] mfd);
    @(negedge clk);
    while (busy) @(negedge clk);
    @(posedge clk); #1;
    cmdValid = 1'b1; cmdOp = op; fracMode = frac;
    reqMfi = mfi; reqRdiv = rdiv; reqOdiv = odiv; reqMfn = mfn; reqMfd = mfd;
    @(posedge clk); #1;
    cmdValid = 1'b0; cmdOp = 2'b00;
  endtask

  task automatic waitDone();
    @(negedge clk);
    while (!done) @(negedge clk);
    @(negedge clk);
    chk("R2", "done after end", {31'b0, done}, 32'h0);
    chk("R2", "busy after end", {31'b0, busy}, 32'h0);
  endtask

  initial begin
    #(150000 * 8);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    exp_t e;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "reset control", ctrlWord, 32'h0001_0000);
    chk("R1", "reset divider", divWord, 32'h0);
    chk("R1", "reset numerator", numWord, 32'h0);
    chk("R1", "reset denominator", denWord, 32'h0);
    chk("R1", "reset status", {27'b0, busy, done, numLoad, seqError, mfnMismatch}, 32'h0);

    // R9 prepare with no lock: times out with bypass kept
    lockEn = 1'b0;
    e = newExp("R9"); e.ctrl = 32'h0001_0007; e.err = 1'b1; e.nLoad = 1; e.nTrace = 3;
    e.trace[0] = 32'h0001_0004; e.trace[1] = 32'h0001_0005; e.trace[2] = 32'h0001_0007;
    e.chkTout = 1'b1;
    q.push_back(e);
    sendCmd(2'b10, 1'b1, 9'd0, 3'd0, 8'd0, 30'd0, 30'd0);
    waitDone();

    // R3 R4 R5 set-rate fractional, with an ignored command while busy (R2)
    lockEn = 1'b1;
    e = newExp("R3"); e.ctrl = 32'h0000_0003; e.dv = 32'h00A2_0006; e.num = 32'd200; e.den = 32'd100;
    e.nLoad = 1; e.nTrace = 6; e.chkSettle = 1'b1;
    e.trace[0] = 32'h7; e.trace[1] = 32'h5; e.trace[2] = 32'h4;
    e.trace[3] = 32'h0; e.trace[4] = 32'h1; e.trace[5] = 32'h3;
    q.push_back(e);
    sendCmd(2'b01, 1'b1, 9'd162, 3'd0, 8'd6, 30'd50, 30'd100);
    repeat (10) @(posedge clk);
    #1 cmdValid = 1'b1; cmdOp = 2'b11;
    @(posedge clk); #1 cmdValid = 1'b0; cmdOp = 2'b00;
    waitDone();
    repeat (30) @(negedge clk);
    chk("R2", "busy after ignored command", {31'b0, busy}, 32'h0);
    chk("R2", "control after ignored command", ctrlWord, 32'h3);

    // R7 mismatch on a wrong echo
    badEcho = 1'b1;
    e = newExp("R7"); e.ctrl = 32'h3; e.dv = 32'h00AD_2008; e.num = 32'd100; e.den = 32'd100;
    e.mism = 1'b1; e.nLoad = 1; e.nTrace = 4;
    e.trace[0] = 32'h1; e.trace[1] = 32'h0; e.trace[2] = 32'h1; e.trace[3] = 32'h3;
    q.push_back(e);
    sendCmd(2'b01, 1'b1, 9'd173, 3'd1, 8'd8, 30'd25, 30'd100);
    waitDone();
    badEcho = 1'b0;

    // R8 prepare when already powered (also clears the mismatch flag, R7)
    e = newExp("R8"); e.ctrl = 32'h3; e.dv = 32'h00AD_2008; e.num = 32'd100; e.den = 32'd100;
    e.chkShort = 1'b1;
    q.push_back(e);
    sendCmd(2'b10, 1'b1, 9'd0, 3'd0, 8'd0, 30'd0, 30'd0);
    waitDone();

    // R10 unprepare clears power only
    e = newExp("R10"); e.ctrl = 32'h2; e.dv = 32'h00AD_2008; e.num = 32'd100; e.den = 32'd100;
    e.nTrace = 1; e.trace[0] = 32'h2;
    q.push_back(e);
    sendCmd(2'b11, 1'b0, 9'd0, 3'd0, 8'd0, 30'd0, 30'd0);
    waitDone();

    // R9 prepare with lock
    e = newExp("R9"); e.ctrl = 32'h3; e.dv = 32'h00AD_2008; e.num = 32'd100; e.den = 32'd100;
    e.nLoad = 1; e.nTrace = 3;
    e.trace[0] = 32'h6; e.trace[1] = 32'h7; e.trace[2] = 32'h3;
    q.push_back(e);
    sendCmd(2'b10, 1'b1, 9'd0, 3'd0, 8'd0, 30'd0, 30'd0);
    waitDone();

    // R4 integer set-rate leaves fraction words alone
    e = newExp("R4"); e.ctrl = 32'h3; e.dv = 32'h008D_2002; e.num = 32'd100; e.den = 32'd100;
    e.nTrace = 4;
    e.trace[0] = 32'h1; e.trace[1] = 32'h0; e.trace[2] = 32'h1; e.trace[3] = 32'h3;
    q.push_back(e);
    sendCmd(2'b01, 1'b0, 9'd141, 3'd1, 8'd2, 30'd25, 30'd7);
    waitDone();

    // R6 set-rate lock timeout leaves output disabled
    lockEn = 1'b0;
    e = newExp("R6"); e.ctrl = 32'h1; e.dv = 32'h00AF_2003; e.num = 32'd100; e.den = 32'd100;
    e.err = 1'b1; e.nTrace = 3; e.chkTout = 1'b1;
    e.trace[0] = 32'h1; e.trace[1] = 32'h0; e.trace[2] = 32'h1;
    q.push_back(e);
    sendCmd(2'b01, 1'b0, 9'd175, 3'd1, 8'd3, 30'd25, 30'd0);
    waitDone();

    // R7 next command clears the error flag
    lockEn = 1'b1;
    e = newExp("R7"); e.ctrl = 32'h1; e.dv = 32'h00AF_2003; e.num = 32'd100; e.den = 32'd100;
    e.chkShort = 1'b1;
    q.push_back(e);
    sendCmd(2'b10, 1'b0, 9'd0, 3'd0, 8'd0, 30'd0, 30'd0);
    waitDone();

    chk("R2", "scoreboard drained", q.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule